// File: doc/BRIEF.md
# Duty Cycle Measurement Cell

This block times one digital input against the module clock so that software can work out the input's period and the width of its high or low phase. A local up-counter runs on every clock. Chosen input edges clear it, and chosen edges copy its value into two readable registers. Each edge also sets a sticky service flag, can raise an interrupt request, and can emit a one-clock pulse on a dedicated output.

The input is asynchronous. It passes through a two-stage synchronizer, and an edge is detected by comparing the synchronized sample with the sample taken one cycle earlier. Which edge kinds clear the counter, which edge feeds which register, and which edges raise requests or pulses are all set by separate control bits.

For an input that has stopped toggling, which is the 0 % or 100 % duty case, the secondary register can instead hold a programmed maximum period. When the counter reaches that value before it is cleared again, a limit flag and an interrupt request are raised.

Top module: `duty_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, both registers, all three flags, `irq` and `pulse_out` become 0.
- R2: On any clock where no enabled clearing edge is detected, `count` rises by exactly one. It wraps from all-ones (0xFFFFFF at the default width) to zero.
- R3: A detected rising edge clears `count` to 0 when `cfg_rise_zero` is 1. A detected falling edge clears it when `cfg_fall_zero` is 1. An edge of a kind whose clear bit is 0 does not clear the counter.
- R4: A change on `sig_in` applied between two clock edges takes effect at the third rising clock edge after it. At that edge the flags, registers, counter, `irq` and `pulse_out` all update, and none of them reacts earlier.
- R5: `cap_main` takes the counter value on rising edges when `cfg_cap_on_rise` is 1, and on falling edges when it is 0. If the same edge also clears the counter, the stored value is the count from before the clear.
- R6: Outside limit mode, `cap_aux` takes the counter value on the edge opposite to the one that feeds `cap_main`, but only when `cfg_aux_cap_en` is 1. Otherwise it keeps its value unless `lim_wr` writes it.
- R7: Every rising edge sets `flag_rise`, and every falling edge sets `flag_fall`, whatever the enable bits are. A flag stays set until its clear strobe is high at a clock edge. If a new edge is detected in the same cycle as the clear, the flag stays set.
- R8: `irq` is high for one cycle after a rising edge when `cfg_rise_irq_en` is 1, after a falling edge when `cfg_fall_irq_en` is 1, and after a limit hit. It is low otherwise.
- R9: `pulse_out` is high for exactly one cycle after a rising edge when `cfg_rise_pulse_en` is 1, and after a falling edge when `cfg_fall_pulse_en` is 1. It is low otherwise.
- R10: A high `lim_wr` loads `lim_wdata` into `cap_aux`, taking priority over a capture. When `cfg_limit_mode` is 1, the counter equals `cap_aux`, and no clearing edge is detected in that cycle, `flag_limit` is set and `irq` pulses. In limit mode, edges never overwrite `cap_aux`.
- R11: `flag_limit` stays set until `clr_limit` is high at a clock edge. A new limit hit in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Asynchronous signal being measured |
| cfg_rise_zero | input | 1 | Rising edge clears the counter |
| cfg_fall_zero | input | 1 | Falling edge clears the counter |
| cfg_cap_on_rise | input | 1 | 1: rising edge feeds cap_main; 0: falling edge |
| cfg_aux_cap_en | input | 1 | Opposite edge feeds cap_aux |
| cfg_rise_irq_en | input | 1 | Rising edge raises irq |
| cfg_fall_irq_en | input | 1 | Falling edge raises irq |
| cfg_rise_pulse_en | input | 1 | Rising edge drives pulse_out |
| cfg_fall_pulse_en | input | 1 | Falling edge drives pulse_out |
| cfg_limit_mode | input | 1 | cap_aux acts as period limit |
| lim_wr | input | 1 | Write strobe for cap_aux |
| lim_wdata | input | 24 | Value written into cap_aux |
| clr_rise | input | 1 | Clears flag_rise |
| clr_fall | input | 1 | Clears flag_fall |
| clr_limit | input | 1 | Clears flag_limit |
| count | output | 24 | Current counter value |
| cap_main | output | 24 | Primary capture register |
| cap_aux | output | 24 | Secondary capture / limit register |
| flag_rise | output | 1 | Sticky rising-edge flag |
| flag_fall | output | 1 | Sticky falling-edge flag |
| flag_limit | output | 1 | Sticky limit-exceeded flag |
| irq | output | 1 | One-cycle interrupt request |
| pulse_out | output | 1 | One-cycle edge pulse |

## Verification
Every edge-driven result is due at the third rising clock edge after `sig_in` changes: two edges fill the synchronizer, and the third edge writes the registered outputs. A register write or clear strobe shows its effect at the very next edge, as does a limit hit on the cycle where the count matches. The bench drives all inputs on falling clock edges. It advances a cycle-level expected model on each rising edge and compares every output at the following falling edge, so each result is checked in the exact cycle it becomes due and in no other. Directed cases confirm the latency boundary by sampling one cycle before and at the due edge.

// File: rtl/duty_meter_pkg.sv
// Shared types for the duty cycle measurement cell.
// Assumes: single clock domain, synchronous active-low reset.
package duty_meter_pkg;

    // Edge events produced by the synchronizer, valid for one clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } dm_edge_t;

    // Control bits gathered from the top-level configuration ports.
    typedef struct packed {
        logic rise_zero;
        logic fall_zero;
        logic cap_on_rise;
        logic aux_cap_en;
        logic rise_irq_en;
        logic fall_irq_en;
        logic rise_pulse_en;
        logic fall_pulse_en;
        logic limit_mode;
    } dm_cfg_t;

endpackage

// File: rtl/dm_sync_edge.sv
// Synchronizes the asynchronous input through STAGES flops and reports
// a rising or falling edge by comparing the last stage with one extra
// delayed copy. Assumes STAGES >= 2; reset value of every stage is 0.
module dm_sync_edge
    import duty_meter_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sig_async,
    output dm_edge_t edges
);
    localparam int LAST = STAGES;

    // pipe_q[0] is the first sampling flop, pipe_q[LAST] the previous sample.
    logic [LAST:0] pipe_q;

    // Shift the input through the synchronizer and history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[LAST-1:0], sig_async};
    end

    // Compare the settled sample against the one a cycle older.
    always_comb begin
        edges.rise = pipe_q[LAST-1] & ~pipe_q[LAST];
        edges.fall = ~pipe_q[LAST-1] & pipe_q[LAST];
    end

    // R4: an edge report always follows a change seen at the first stage earlier.
    a_r4_rise_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        edges.rise |-> $past(pipe_q[0]));

endmodule

// File: rtl/dm_timer.sv
// Local up-counter: cleared by enabled edges, otherwise free-running with
// wrap-around. Also compares the count against the limit value.
// Assumes edges are one-cycle events from dm_sync_edge.
module dm_timer
    import duty_meter_pkg::*;
#(
    parameter int TIMER_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dm_edge_t           edges,
    input  logic               rise_zero,
    input  logic               fall_zero,
    input  logic               limit_mode,
    input  logic [TIMER_W-1:0] limit_val,
    output logic [TIMER_W-1:0] count_q,
    output logic               limit_hit
);
    logic zero_req;

    // An enabled edge kind requests a counter clear.
    assign zero_req  = (edges.rise & rise_zero) | (edges.fall & fall_zero);
    // Limit reached without a clear arriving in the same cycle.
    assign limit_hit = limit_mode & (count_q == limit_val) & ~zero_req;

    // Count up every clock, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (zero_req) count_q <= '0;
        else               count_q <= count_q + 1'b1;
    end

    // R2: without a clear the counter steps by exactly one (modulo width).
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_req |=> (count_q == TIMER_W'($past(count_q) + 1'b1)));

    // R3: a clear request lands as zero on the next cycle.
    a_r3_zero_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (count_q == '0));

endmodule

// File: rtl/dm_capture.sv
// Holds the primary and secondary capture registers. The secondary one is
// also loaded by software and acts as the limit in limit mode.
// Assumes count is the counter value before any clear in this cycle.
module dm_capture
    import duty_meter_pkg::*;
#(
    parameter int TIMER_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  dm_edge_t           edges,
    input  logic [TIMER_W-1:0] count,
    input  logic               cap_on_rise,
    input  logic               aux_cap_en,
    input  logic               limit_mode,
    input  logic               lim_wr,
    input  logic [TIMER_W-1:0] lim_wdata,
    output logic [TIMER_W-1:0] cap_main_q,
    output logic [TIMER_W-1:0] cap_aux_q
);
    logic main_take;
    logic aux_take;

    // Select which edge feeds which register.
    assign main_take = cap_on_rise ? edges.rise : edges.fall;
    assign aux_take  = aux_cap_en & ~limit_mode & (cap_on_rise ? edges.fall : edges.rise);

    // Primary register copies the count on its selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         cap_main_q <= '0;
        else if (main_take) cap_main_q <= count;
    end

    // Secondary register: software write first, then opposite-edge capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        cap_aux_q <= '0;
        else if (lim_wr)   cap_aux_q <= lim_wdata;
        else if (aux_take) cap_aux_q <= count;
    end

    // R5: a primary capture stores the pre-clear count of that cycle.
    a_r5_main_capture: assert property (@(posedge clk) disable iff (!rst_n)
        main_take |=> (cap_main_q == $past(count)));

    // R6: with no write and no capture the secondary register holds.
    a_r6_aux_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(aux_take || lim_wr) |=> $stable(cap_aux_q));

    // R10: in limit mode only a write can change the secondary register.
    a_r10_limit_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_mode && !lim_wr) |=> $stable(cap_aux_q));

endmodule

// File: rtl/dm_flags.sv
// Sticky service flags with clear strobes, the one-cycle interrupt request
// and the one-cycle edge pulse. A set always wins over a same-cycle clear.
module dm_flags
    import duty_meter_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  dm_edge_t edges,
    input  logic     limit_hit,
    input  logic     rise_irq_en,
    input  logic     fall_irq_en,
    input  logic     rise_pulse_en,
    input  logic     fall_pulse_en,
    input  logic     clr_rise,
    input  logic     clr_fall,
    input  logic     clr_limit,
    output logic     flag_rise_q,
    output logic     flag_fall_q,
    output logic     flag_limit_q,
    output logic     irq_q,
    output logic     pulse_q
);
    logic irq_src;
    logic pulse_src;

    // Gather enabled request and pulse sources.
    assign irq_src   = (edges.rise & rise_irq_en) | (edges.fall & fall_irq_en) | limit_hit;
    assign pulse_src = (edges.rise & rise_pulse_en) | (edges.fall & fall_pulse_en);

    // Update flags (set over clear) and register the one-cycle outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_rise_q  <= 1'b0;
            flag_fall_q  <= 1'b0;
            flag_limit_q <= 1'b0;
            irq_q        <= 1'b0;
            pulse_q      <= 1'b0;
        end else begin
            flag_rise_q  <= edges.rise | (flag_rise_q & ~clr_rise);
            flag_fall_q  <= edges.fall | (flag_fall_q & ~clr_fall);
            flag_limit_q <= limit_hit  | (flag_limit_q & ~clr_limit);
            irq_q        <= irq_src;
            pulse_q      <= pulse_src;
        end
    end

    // R7: any rising edge leaves the rising flag set.
    a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        edges.rise |=> flag_rise_q);

    // R8: no enabled source means no request next cycle.
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(edges.rise && rise_irq_en) && !(edges.fall && fall_irq_en) && !limit_hit |=> !irq_q);

    // R9: an enabled falling edge produces the pulse.
    a_r9_pulse_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (edges.fall && fall_pulse_en) |=> pulse_q);

    // R10: a limit hit sets the flag and raises a request.
    a_r10_limit_flag: assert property (@(posedge clk) disable iff (!rst_n)
        limit_hit |=> (flag_limit_q && irq_q));

endmodule

// File: rtl/duty_meter.sv
// Top of the duty cycle measurement cell. Gathers the configuration bits,
// then wires synchronizer, counter, capture registers and flag logic.
// Assumes all ports except sig_in are synchronous to clk.
module duty_meter
    import duty_meter_pkg::*;
#(
    parameter int TIMER_W     = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sig_in,
    input  logic               cfg_rise_zero,
    input  logic               cfg_fall_zero,
    input  logic               cfg_cap_on_rise,
    input  logic               cfg_aux_cap_en,
    input  logic               cfg_rise_irq_en,
    input  logic               cfg_fall_irq_en,
    input  logic               cfg_rise_pulse_en,
    input  logic               cfg_fall_pulse_en,
    input  logic               cfg_limit_mode,
    input  logic               lim_wr,
    input  logic [TIMER_W-1:0] lim_wdata,
    input  logic               clr_rise,
    input  logic               clr_fall,
    input  logic               clr_limit,
    output logic [TIMER_W-1:0] count,
    output logic [TIMER_W-1:0] cap_main,
    output logic [TIMER_W-1:0] cap_aux,
    output logic               flag_rise,
    output logic               flag_fall,
    output logic               flag_limit,
    output logic               irq,
    output logic               pulse_out
);
    dm_cfg_t  cfg;
    dm_edge_t edges;
    logic     limit_hit;

    // Collect the configuration ports into one record.
    always_comb begin
        cfg.rise_zero     = cfg_rise_zero;
        cfg.fall_zero     = cfg_fall_zero;
        cfg.cap_on_rise   = cfg_cap_on_rise;
        cfg.aux_cap_en    = cfg_aux_cap_en;
        cfg.rise_irq_en   = cfg_rise_irq_en;
        cfg.fall_irq_en   = cfg_fall_irq_en;
        cfg.rise_pulse_en = cfg_rise_pulse_en;
        cfg.fall_pulse_en = cfg_fall_pulse_en;
        cfg.limit_mode    = cfg_limit_mode;
    end

    dm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_async (sig_in),
        .edges     (edges)
    );

    dm_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .edges      (edges),
        .rise_zero  (cfg.rise_zero),
        .fall_zero  (cfg.fall_zero),
        .limit_mode (cfg.limit_mode),
        .limit_val  (cap_aux),
        .count_q    (count),
        .limit_hit  (limit_hit)
    );

    dm_capture #(.TIMER_W(TIMER_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .edges       (edges),
        .count       (count),
        .cap_on_rise (cfg.cap_on_rise),
        .aux_cap_en  (cfg.aux_cap_en),
        .limit_mode  (cfg.limit_mode),
        .lim_wr      (lim_wr),
        .lim_wdata   (lim_wdata),
        .cap_main_q  (cap_main),
        .cap_aux_q   (cap_aux)
    );

    dm_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .edges         (edges),
        .limit_hit     (limit_hit),
        .rise_irq_en   (cfg.rise_irq_en),
        .fall_irq_en   (cfg.fall_irq_en),
        .rise_pulse_en (cfg.rise_pulse_en),
        .fall_pulse_en (cfg.fall_pulse_en),
        .clr_rise      (clr_rise),
        .clr_fall      (clr_fall),
        .clr_limit     (clr_limit),
        .flag_rise_q   (flag_rise),
        .flag_fall_q   (flag_fall),
        .flag_limit_q  (flag_limit),
        .irq_q         (irq),
        .pulse_q       (pulse_out)
    );

    // R1: after a reset cycle nothing is pending on the event outputs.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!irq && !pulse_out && !flag_rise && !flag_fall && !flag_limit));

endmodule

// File: tb/duty_meter_tb_top.sv
`timescale 1ns/100ps
module duty_meter_tb_top;
    localparam int W  = 24;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_in = 1'b0;
    logic [8:0] cfg = '0; // {rz,fz,cor,aux,ri,fi,rp,fp,lim}
    logic lim_wr = 1'b0;
    logic [W-1:0] lim_wdata = '0;
    logic clr_rise = 1'b0, clr_fall = 1'b0, clr_limit = 1'b0;

    logic [W-1:0] count, cap_main, cap_aux;
    logic flag_rise, flag_fall, flag_limit, irq, pulse_out;

    logic [SW-1:0] s_count, s_main, s_aux;
    logic s_fr, s_ff, s_fl, s_irq, s_pls;

    int n_checks = 0;
    int n_err = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    duty_meter #(.TIMER_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
        .cfg_rise_zero(cfg[8]), .cfg_fall_zero(cfg[7]), .cfg_cap_on_rise(cfg[6]),
        .cfg_aux_cap_en(cfg[5]), .cfg_rise_irq_en(cfg[4]), .cfg_fall_irq_en(cfg[3]),
        .cfg_rise_pulse_en(cfg[2]), .cfg_fall_pulse_en(cfg[1]), .cfg_limit_mode(cfg[0]),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata),
        .clr_rise(clr_rise), .clr_fall(clr_fall), .clr_limit(clr_limit),
        .count(count), .cap_main(cap_main), .cap_aux(cap_aux),
        .flag_rise(flag_rise), .flag_fall(flag_fall), .flag_limit(flag_limit),
        .irq(irq), .pulse_out(pulse_out)
    );

    // Narrow instance, inputs idle, used only to reach the counter wrap quickly.
    duty_meter #(.TIMER_W(SW)) wrap_i (
        .clk(clk), .rst_n(rst_n), .sig_in(1'b0),
        .cfg_rise_zero(1'b0), .cfg_fall_zero(1'b0), .cfg_cap_on_rise(1'b0),
        .cfg_aux_cap_en(1'b0), .cfg_rise_irq_en(1'b0), .cfg_fall_irq_en(1'b0),
        .cfg_rise_pulse_en(1'b0), .cfg_fall_pulse_en(1'b0), .cfg_limit_mode(1'b0),
        .lim_wr(1'b0), .lim_wdata('0),
        .clr_rise(1'b0), .clr_fall(1'b0), .clr_limit(1'b0),
        .count(s_count), .cap_main(s_main), .cap_aux(s_aux),
        .flag_rise(s_fr), .flag_fall(s_ff), .flag_limit(s_fl),
        .irq(s_irq), .pulse_out(s_pls)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Expected-behaviour model, advanced on each rising edge from the requirements.
    logic m_s1 = 0, m_s2 = 0, m_s3 = 0;
    logic [W-1:0] m_cnt = '0, m_main = '0, m_aux = '0;
    logic m_fr = 0, m_ff = 0, m_fl = 0, m_irq = 0, m_pls = 0;
    logic [SW-1:0] w_cnt = '0;

    function automatic logic zero_of(input logic r, input logic f, input logic [8:0] c);
        return (r & c[8]) | (f & c[7]);
    endfunction

    always @(posedge clk) begin
        logic r, f, zr, hit;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_cnt = '0; m_main = '0; m_aux = '0;
            m_fr = 0; m_ff = 0; m_fl = 0; m_irq = 0; m_pls = 0;
            w_cnt = '0;
        end else begin
            r   = m_s2 & ~m_s3;
            f   = ~m_s2 & m_s3;
            zr  = zero_of(r, f, cfg);
            hit = cfg[0] && (m_cnt == m_aux) && !zr;
            if (cfg[6] ? r : f) m_main = m_cnt;
            if (lim_wr) m_aux = lim_wdata;
            else if (cfg[5] && !cfg[0] && (cfg[6] ? f : r)) m_aux = m_cnt;
            m_cnt = zr ? '0 : m_cnt + 1'b1;
            m_fr  = r | (m_fr & ~clr_rise);
            m_ff  = f | (m_ff & ~clr_fall);
            m_fl  = hit | (m_fl & ~clr_limit);
            m_irq = (r & cfg[4]) | (f & cfg[3]) | hit;
            m_pls = (r & cfg[2]) | (f & cfg[1]);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig_in;
            w_cnt = w_cnt + 1'b1;
        end
    end

    // Compare every output in the middle of each cycle.
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R2/R3 count", count, m_cnt);
            chk("R5 cap_main", cap_main, m_main);
            chk("R6/R10 cap_aux", cap_aux, m_aux);
            chk("R7 flag_rise", flag_rise, m_fr);
            chk("R7 flag_fall", flag_fall, m_ff);
            chk("R11 flag_limit", flag_limit, m_fl);
            chk("R8 irq", irq, m_irq);
            chk("R9 pulse_out", pulse_out, m_pls);
            chk("R2 wrap count", s_count, w_cnt);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] snap;
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 count", count, 0);
        chk("R1 cap_main", cap_main, 0);
        chk("R1 cap_aux", cap_aux, 0);
        chk("R1 flags", {flag_rise, flag_fall, flag_limit}, 0);
        chk("R1 irq/pulse", {irq, pulse_out}, 0);
        rst_n = 1'b1;
        chk_on = 1'b1;

        // R4: latency boundary of an edge
        @(negedge clk) sig_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) chk("R4 not yet", flag_rise, 0);
        @(negedge clk) chk("R4 due", flag_rise, 1);

        // R5 with R3: clear and capture on the same rising edge
        cfg = 9'b1_0_1_0_0_0_0_0_0;
        @(negedge clk) sig_in = 1'b0;
        repeat (20) @(negedge clk);
        sig_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) snap = count;
        @(negedge clk);
        chk("R5 pre-clear value", cap_main, snap);
        chk("R3 cleared", count, 0);

        // R10: limit mode, rise clears, aux capture enabled but suppressed
        cfg = 9'b1_0_1_1_0_0_0_0_1;
        @(negedge clk) begin sig_in = 1'b0; lim_wr = 1'b1; lim_wdata = 24'd40; end
        @(negedge clk) lim_wr = 1'b0;
        repeat (4) @(negedge clk);
        sig_in = 1'b1;
        repeat (10) @(negedge clk);
        sig_in = 1'b0;
        repeat (50) @(negedge clk);
        chk("R10 limit flag", flag_limit, 1);
        chk("R10 aux kept", cap_aux, 40);

        // R11: clear the limit flag
        cfg = '0;
        clr_limit = 1'b1;
        @(negedge clk) clr_limit = 1'b0;
        chk("R11 cleared", flag_limit, 0);

        // Random segments: config, toggling, clears, limit writes
        for (int seg = 0; seg < 40; seg++) begin
            int tog;
            cfg = 9'($urandom);
            tog = 2 + int'($urandom % 30);
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                if ($urandom % tog == 0) sig_in = ~sig_in;
                clr_rise  = ($urandom % 8 == 0);
                clr_fall  = ($urandom % 8 == 0);
                clr_limit = ($urandom % 8 == 0);
                lim_wr    = ($urandom % 64 == 0);
                lim_wdata = W'($urandom % 160);
            end
        end
        @(negedge clk);
        {clr_rise, clr_fall, clr_limit, lim_wr} = '0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule